// File: doc/BRIEF.md
# Dual-Bank Memory Mode Router

This block sits between two local SRAM banks and two masters: a host-bus port and a reconfigurable-logic port. Each bank holds 2^AW half-words of 16 bits with two byte enables and returns read data one cycle after it is enabled. A mode register selects the bank topology at run time. In the two wide modes both banks receive the same address and together form one 32-bit word owned by a single master. In the two split modes each master owns one bank as a 16-bit memory. In the dual mode the logic side drives both banks in the same cycle with two independent addresses and can ring a doorbell interrupt toward the host.

Both master ports use a valid/ready request channel. A request transfers on a cycle where valid and ready are both high. While valid is high without ready, the master keeps its fields stable, with one exception: a request that is flagged with the port's error output will never be accepted, and the master may withdraw it. Read data comes back on an rvalid/rdata pair exactly one cycle after the read is accepted. The return path has no back-pressure, so the master must take the data in that cycle. Writes complete on acceptance and produce no response. Because ownership is exclusive in every mode, the two masters never compete for a bank and no arbitration is needed.

Top module: `bank_mode_router`

## Requirements
- R1: After reset the mode is host-wide (code 0), mode_busy is low, irq is low and neither rvalid is high.
- R2: In mode 0 (host-wide) a host request drives address bits [AW-1:0] to both banks. Bank 0 carries data bits [15:0] with byte enables [1:0], and bank 1 carries bits [31:16] with enables [3:2]. A host read returns {bank1, bank0}. Address bit AW is disregarded.
- R3: In mode 1 (logic-wide) the logic port has the same 32-bit access that R2 gives the host.
- R4: Mode 2 gives bank 0 to the host and bank 1 to the logic side. Mode 3 swaps the two. In these modes address bit AW selects the bank (0 selects bank 0, 1 selects bank 1). Data uses bits [15:0] with enables [1:0], and the upper read half-word is zero.
- R5: In mode 4 (dual) a logic request with address bit AW clear accesses bank 0 at l_addr[AW-1:0] and bank 1 at l_addr2 in the same cycle, with the half-word mapping of R2.
- R6: A request that targets a bank its master does not own is never forwarded. The port's ready stays low, its err output is high while valid is high, and no bank is enabled for it. This also applies to every host request in modes 1 and 4 other than the R8 clear.
- R7: A valid mode_set with mode_code 0 to 4 takes effect only after every accepted read has returned. From the cycle after mode_set until the switch, mode_busy is high and both ready outputs are low. Codes 5 to 7 are ignored.
- R8: In mode 4, a logic write with address bit AW set raises irq and holds it high. A host write with address bit AW set clears irq. If both occur in the same cycle, irq ends up set.
- R9: An accepted read returns rvalid high for exactly one cycle, one cycle after acceptance. Accepted writes give no rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_set | input | 1 | Request a mode change |
| mode_code | input | 3 | Requested mode |
| mode_cur | output | 3 | Mode in force |
| mode_busy | output | 1 | Mode change pending |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted |
| h_we | input | 1 | Host write |
| h_addr | input | AW+1 | Host address, top bit selects bank or clear |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 32 | Host read data |
| h_err | output | 1 | Host request not owned |
| l_valid | input | 1 | Logic request valid |
| l_ready | output | 1 | Logic request accepted |
| l_we | input | 1 | Logic write |
| l_addr | input | AW+1 | Logic address, top bit selects bank or doorbell |
| l_addr2 | input | AW | Bank 1 address in dual mode |
| l_be | input | 4 | Logic byte enables |
| l_wdata | input | 32 | Logic write data |
| l_rvalid | output | 1 | Logic read data valid |
| l_rdata | output | 32 | Logic read data |
| l_err | output | 1 | Logic request not owned |
| b0_en | output | 1 | Bank 0 enable |
| b0_we | output | 1 | Bank 0 write |
| b0_addr | output | AW | Bank 0 address |
| b0_be | output | 2 | Bank 0 byte enables |
| b0_wdata | output | 16 | Bank 0 write data |
| b0_rdata | input | 16 | Bank 0 read data |
| b1_en | output | 1 | Bank 1 enable |
| b1_we | output | 1 | Bank 1 write |
| b1_addr | output | AW | Bank 1 address |
| b1_be | output | 2 | Bank 1 byte enables |
| b1_wdata | output | 16 | Bank 1 write data |
| b1_rdata | input | 16 | Bank 1 read data |
| irq | output | 1 | Doorbell interrupt level |

## Verification
The bench issues a mode change in the same cycle as an accepted read. A router that switched topology at once would route that read's return through the wrong lanes or let a new request slip in under the old owner. Partial byte-enable writes in the wide modes catch swapped half-words or misrouted enables, which would show up as corrupted bytes on a later full read-back. Non-owner requests in every mode are checked for a silent bank write, and a missing error flag would leave a master stalled without notice. The doorbell set and clear, including both in one cycle, is checked for a dropped or stuck interrupt level.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [2:0] {
    MD_HOST32  = 3'd0,
    MD_LOGIC32 = 3'd1,
    MD_SPLIT_A = 3'd2,
    MD_SPLIT_B = 3'd3,
    MD_DUAL    = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    LN_NONE = 2'd0,
    LN_B0   = 2'd1,
    LN_B1   = 2'd2,
    LN_BOTH = 2'd3
  } lane_e;

  function automatic logic mode_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/bmr_mode_ctl.sv
module bmr_mode_ctl
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_i,
  input  logic [2:0] code_i,
  input  logic       idle_i,
  output mode_e      mode_o,
  output logic       busy_o
);
  mode_e nxt_q;
  logic  pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= MD_HOST32;
      nxt_q  <= MD_HOST32;
      pend_q <= 1'b0;
    end else if (set_i && mode_legal(code_i)) begin
      nxt_q  <= mode_e'(code_i);
      pend_q <= 1'b1;
    end else if (pend_q && idle_i) begin
      mode_o <= nxt_q;
      pend_q <= 1'b0;
    end
  end

  assign busy_o = pend_q;
endmodule

// File: rtl/bmr_steer.sv
module bmr_steer
  import bmr_pkg::*;
#(
  parameter int AW = 19
) (
  input  mode_e             mode,
  input  logic              hold,
  input  logic              h_valid,
  input  logic              h_we,
  input  logic [AW:0]       h_addr,
  input  logic [3:0]        h_be,
  input  logic [31:0]       h_wdata,
  input  logic              l_valid,
  input  logic              l_we,
  input  logic [AW:0]       l_addr,
  input  logic [AW-1:0]     l_addr2,
  input  logic [3:0]        l_be,
  input  logic [31:0]       l_wdata,
  output logic              h_ready,
  output logic              h_err,
  output logic              l_ready,
  output logic              l_err,
  output logic              h_rd,
  output lane_e             h_lane,
  output logic              l_rd,
  output lane_e             l_lane,
  output logic              h_clr,
  output logic              l_bell,
  output logic              b0_en,
  output logic              b0_we,
  output logic [AW-1:0]     b0_addr,
  output logic [1:0]        b0_be,
  output logic [15:0]       b0_wdata,
  output logic              b1_en,
  output logic              b1_we,
  output logic [AW-1:0]     b1_addr,
  output logic [1:0]        b1_be,
  output logic [15:0]       b1_wdata
);
  logic h_ok, l_ok, h_spec, l_spec, h_go, l_go;
  logic h_sel, l_sel;

  assign h_sel = h_addr[AW];
  assign l_sel = l_addr[AW];

  always_comb begin
    h_ok = 1'b0; l_ok = 1'b0; h_spec = 1'b0; l_spec = 1'b0;
    h_lane = LN_NONE; l_lane = LN_NONE;
    case (mode)
      MD_HOST32:  begin h_ok = 1'b1; h_lane = LN_BOTH; end
      MD_LOGIC32: begin l_ok = 1'b1; l_lane = LN_BOTH; end
      MD_SPLIT_A: begin
        h_ok = !h_sel; h_lane = LN_B0;
        l_ok = l_sel;  l_lane = LN_B1;
      end
      MD_SPLIT_B: begin
        h_ok = h_sel;  h_lane = LN_B1;
        l_ok = !l_sel; l_lane = LN_B0;
      end
      MD_DUAL: begin
        h_ok   = h_sel && h_we;
        h_spec = 1'b1;
        l_ok   = !l_sel || l_we;
        l_spec = l_sel;
        l_lane = l_sel ? LN_NONE : LN_BOTH;
      end
      default: ;
    endcase
  end

  assign h_go    = h_valid && h_ok && !hold;
  assign l_go    = l_valid && l_ok && !hold;
  assign h_ready = h_ok && !hold;
  assign l_ready = l_ok && !hold;
  assign h_err   = h_valid && !h_ok;
  assign l_err   = l_valid && !l_ok;
  assign h_rd    = h_go && !h_we && (h_lane != LN_NONE);
  assign l_rd    = l_go && !l_we && (l_lane != LN_NONE);
  assign h_clr   = h_go && h_spec;
  assign l_bell  = l_go && l_spec;

  // bank 0: only ever the low half-word of either master
  always_comb begin
    b0_en = 1'b0; b0_we = 1'b0; b0_addr = '0; b0_be = '0; b0_wdata = '0;
    if (h_go && (h_lane == LN_B0 || h_lane == LN_BOTH)) begin
      b0_en = 1'b1; b0_we = h_we; b0_addr = h_addr[AW-1:0];
      b0_be = h_be[1:0]; b0_wdata = h_wdata[15:0];
    end else if (l_go && (l_lane == LN_B0 || l_lane == LN_BOTH)) begin
      b0_en = 1'b1; b0_we = l_we; b0_addr = l_addr[AW-1:0];
      b0_be = l_be[1:0]; b0_wdata = l_wdata[15:0];
    end
  end

  // bank 1: high half in wide/dual access, low half in split access
  always_comb begin
    b1_en = 1'b0; b1_we = 1'b0; b1_addr = '0; b1_be = '0; b1_wdata = '0;
    if (h_go && h_lane == LN_BOTH) begin
      b1_en = 1'b1; b1_we = h_we; b1_addr = h_addr[AW-1:0];
      b1_be = h_be[3:2]; b1_wdata = h_wdata[31:16];
    end else if (h_go && h_lane == LN_B1) begin
      b1_en = 1'b1; b1_we = h_we; b1_addr = h_addr[AW-1:0];
      b1_be = h_be[1:0]; b1_wdata = h_wdata[15:0];
    end else if (l_go && l_lane == LN_BOTH) begin
      b1_en = 1'b1; b1_we = l_we;
      b1_addr = (mode == MD_DUAL) ? l_addr2 : l_addr[AW-1:0];
      b1_be = l_be[3:2]; b1_wdata = l_wdata[31:16];
    end else if (l_go && l_lane == LN_B1) begin
      b1_en = 1'b1; b1_we = l_we; b1_addr = l_addr[AW-1:0];
      b1_be = l_be[1:0]; b1_wdata = l_wdata[15:0];
    end
  end
endmodule

// File: rtl/bmr_rsp_track.sv
module bmr_rsp_track
  import bmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_i,
  input  lane_e       lane_i,
  input  logic [15:0] b0_rdata,
  input  logic [15:0] b1_rdata,
  output logic        rvalid_o,
  output logic [31:0] rdata_o
);
  lane_e lane_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      lane_q   <= LN_NONE;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) lane_q <= lane_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rvalid_o) begin
      case (lane_q)
        LN_BOTH: rdata_o = {b1_rdata, b0_rdata};
        LN_B0:   rdata_o = {16'h0, b0_rdata};
        LN_B1:   rdata_o = {16'h0, b1_rdata};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bmr_doorbell.sv
module bmr_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_i,
  input  logic clear_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_o <= 1'b0;
    else if (ring_i)  irq_o <= 1'b1;
    else if (clear_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/bank_mode_router.sv
module bank_mode_router
  import bmr_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_set,
  input  logic [2:0]        mode_code,
  output logic [2:0]        mode_cur,
  output logic              mode_busy,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_we,
  input  logic [AW:0]       h_addr,
  input  logic [3:0]        h_be,
  input  logic [31:0]       h_wdata,
  output logic              h_rvalid,
  output logic [31:0]       h_rdata,
  output logic              h_err,
  input  logic              l_valid,
  output logic              l_ready,
  input  logic              l_we,
  input  logic [AW:0]       l_addr,
  input  logic [AW-1:0]     l_addr2,
  input  logic [3:0]        l_be,
  input  logic [31:0]       l_wdata,
  output logic              l_rvalid,
  output logic [31:0]       l_rdata,
  output logic              l_err,
  output logic              b0_en,
  output logic              b0_we,
  output logic [AW-1:0]     b0_addr,
  output logic [1:0]        b0_be,
  output logic [15:0]       b0_wdata,
  input  logic [15:0]       b0_rdata,
  output logic              b1_en,
  output logic              b1_we,
  output logic [AW-1:0]     b1_addr,
  output logic [1:0]        b1_be,
  output logic [15:0]       b1_wdata,
  input  logic [15:0]       b1_rdata,
  output logic              irq
);
  mode_e mode;
  logic  h_rd, l_rd, h_clr, l_bell, idle;
  lane_e h_lane, l_lane;

  assign idle     = !h_rvalid && !l_rvalid;
  assign mode_cur = mode;

  bmr_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .set_i(mode_set), .code_i(mode_code),
    .idle_i(idle), .mode_o(mode), .busy_o(mode_busy)
  );

  bmr_steer #(.AW(AW)) u_steer (
    .mode(mode), .hold(mode_busy),
    .h_valid(h_valid), .h_we(h_we), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
    .l_valid(l_valid), .l_we(l_we), .l_addr(l_addr), .l_addr2(l_addr2),
    .l_be(l_be), .l_wdata(l_wdata),
    .h_ready(h_ready), .h_err(h_err), .l_ready(l_ready), .l_err(l_err),
    .h_rd(h_rd), .h_lane(h_lane), .l_rd(l_rd), .l_lane(l_lane),
    .h_clr(h_clr), .l_bell(l_bell),
    .b0_en(b0_en), .b0_we(b0_we), .b0_addr(b0_addr), .b0_be(b0_be), .b0_wdata(b0_wdata),
    .b1_en(b1_en), .b1_we(b1_we), .b1_addr(b1_addr), .b1_be(b1_be), .b1_wdata(b1_wdata)
  );

  bmr_rsp_track u_hrsp (
    .clk(clk), .rst_n(rst_n), .rd_i(h_rd), .lane_i(h_lane),
    .b0_rdata(b0_rdata), .b1_rdata(b1_rdata), .rvalid_o(h_rvalid), .rdata_o(h_rdata)
  );

  bmr_rsp_track u_lrsp (
    .clk(clk), .rst_n(rst_n), .rd_i(l_rd), .lane_i(l_lane),
    .b0_rdata(b0_rdata), .b1_rdata(b1_rdata), .rvalid_o(l_rvalid), .rdata_o(l_rdata)
  );

  bmr_doorbell u_bell (
    .clk(clk), .rst_n(rst_n), .ring_i(l_bell), .clear_i(h_clr), .irq_o(irq)
  );
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_cur,
  input logic       mode_busy,
  input logic       h_valid,
  input logic       h_ready,
  input logic       h_we,
  input logic       h_err,
  input logic       h_rvalid,
  input logic       l_valid,
  input logic       l_ready,
  input logic       l_we,
  input logic       l_err,
  input logic       l_rvalid,
  input logic       b0_en,
  input logic       b1_en,
  input logic       irq
);
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_err && h_ready) && !(l_err && l_ready));

  assert_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == 3'd0 && l_valid) |-> (l_err && !l_ready));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_ready && !l_ready) |-> !(b0_en || b1_en));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_busy |-> !(h_ready || l_ready));

  assert_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur != $past(mode_cur)) |-> $past(mode_busy));

  assert_bell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(l_valid && l_ready && l_we && mode_cur == 3'd4));

  assert_hrsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && !h_we) |=> h_rvalid);

  assert_lrsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && l_ready && !l_we) |=> l_rvalid);
endmodule

bind bank_mode_router bmr_checker chk_i (
  .clk(clk), .rst_n(rst_n), .mode_cur(mode_cur), .mode_busy(mode_busy),
  .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we), .h_err(h_err), .h_rvalid(h_rvalid),
  .l_valid(l_valid), .l_ready(l_ready), .l_we(l_we), .l_err(l_err), .l_rvalid(l_rvalid),
  .b0_en(b0_en), .b1_en(b1_en), .irq(irq)
);

// File: tb/bank_mode_router_tb_top.sv
module bank_mode_router_tb_top;
  localparam int AW = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic mode_set = 0; logic [2:0] mode_code = 0;
  logic [2:0] mode_cur; logic mode_busy;
  logic hv = 0, hwe = 0; logic [AW:0] ha = 0; logic [3:0] hbe = 0; logic [31:0] hwd = 0;
  logic lv = 0, lwe = 0; logic [AW:0] la = 0; logic [AW-1:0] la2 = 0;
  logic [3:0] lbe = 0; logic [31:0] lwd = 0;
  logic h_ready, h_rvalid, h_err, l_ready, l_rvalid, l_err, irq;
  logic [31:0] h_rdata, l_rdata;
  logic b0_en, b0_we, b1_en, b1_we;
  logic [AW-1:0] b0_addr, b1_addr; logic [1:0] b0_be, b1_be;
  logic [15:0] b0_wdata, b1_wdata, b0_rdata, b1_rdata;

  bank_mode_router #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_code(mode_code),
    .mode_cur(mode_cur), .mode_busy(mode_busy),
    .h_valid(hv), .h_ready(h_ready), .h_we(hwe), .h_addr(ha), .h_be(hbe), .h_wdata(hwd),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata), .h_err(h_err),
    .l_valid(lv), .l_ready(l_ready), .l_we(lwe), .l_addr(la), .l_addr2(la2), .l_be(lbe),
    .l_wdata(lwd), .l_rvalid(l_rvalid), .l_rdata(l_rdata), .l_err(l_err),
    .b0_en(b0_en), .b0_we(b0_we), .b0_addr(b0_addr), .b0_be(b0_be), .b0_wdata(b0_wdata),
    .b0_rdata(b0_rdata),
    .b1_en(b1_en), .b1_we(b1_we), .b1_addr(b1_addr), .b1_be(b1_be), .b1_wdata(b1_wdata),
    .b1_rdata(b1_rdata), .irq(irq)
  );

  // bank models: synchronous, one-cycle read
  logic [15:0] sm0 [int];
  logic [15:0] sm1 [int];
  always @(posedge clk) begin : bank0_model
    logic [15:0] t;
    if (b0_en) begin
      t = sm0.exists(int'(b0_addr)) ? sm0[int'(b0_addr)] : 16'h0;
      if (b0_we) begin
        if (b0_be[0]) t[7:0] = b0_wdata[7:0];
        if (b0_be[1]) t[15:8] = b0_wdata[15:8];
        sm0[int'(b0_addr)] = t;
      end else b0_rdata <= t;
    end
  end
  always @(posedge clk) begin : bank1_model
    logic [15:0] t;
    if (b1_en) begin
      t = sm1.exists(int'(b1_addr)) ? sm1[int'(b1_addr)] : 16'h0;
      if (b1_we) begin
        if (b1_be[0]) t[7:0] = b1_wdata[7:0];
        if (b1_be[1]) t[15:8] = b1_wdata[15:8];
        sm1[int'(b1_addr)] = t;
      end else b1_rdata <= t;
    end
  end

  // reference memory built from the requirements
  logic [15:0] rm0 [int];
  logic [15:0] rm1 [int];
  function automatic logic [15:0] rget(input int b, input int a);
    if (b == 0) return rm0.exists(a) ? rm0[a] : 16'h0;
    return rm1.exists(a) ? rm1[a] : 16'h0;
  endfunction
  function automatic void rput(input int b, input int a, input logic [1:0] be, input logic [15:0] d);
    logic [15:0] t;
    t = rget(b, a);
    if (be[0]) t[7:0] = d[7:0];
    if (be[1]) t[15:8] = d[15:8];
    if (b == 0) rm0[a] = t; else rm1[a] = t;
  endfunction

  // 0 reject, 1 both banks, 2 bank0, 3 bank1, 4 doorbell/clear
  function automatic int route_of(input int m, input bit host, input bit we, input bit sel);
    case (m)
      0: return host ? 1 : 0;
      1: return host ? 0 : 1;
      2: return host ? (sel ? 0 : 2) : (sel ? 3 : 0);
      3: return host ? (sel ? 3 : 0) : (sel ? 0 : 2);
      4: return host ? ((sel && we) ? 4 : 0) : (sel ? (we ? 4 : 0) : 1);
      default: return 0;
    endcase
  endfunction

  int errors = 0, checks = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  bit hacc, lacc, herr, lerr, hrv, lrv, en0, en1;
  logic [31:0] hrd, lrd;
  task automatic step();
    #1;
    hacc = hv && h_ready; lacc = lv && l_ready;
    herr = h_err; lerr = l_err; en0 = b0_en; en1 = b1_en;
    @(posedge clk); @(negedge clk);
    hrv = h_rvalid; hrd = h_rdata; lrv = l_rvalid; lrd = l_rdata;
    hv = 0; lv = 0;
  endtask

  function automatic string tag_of(input int m);
    case (m) 0: return "R2"; 1: return "R3"; 2, 3: return "R4"; default: return "R5"; endcase
  endfunction

  task automatic judge(input bit host, input int m, input bit v, input bit we,
                       input logic [AW:0] a, input logic [AW-1:0] a2, input logic [3:0] be,
                       input logic [31:0] wd, input bit acc, input bit er, input bit rv,
                       input logic [31:0] rd);
    int r; int ai; int a2i; logic [31:0] e;
    if (!v) return;
    r = route_of(m, host, we, a[AW]);
    ai = int'(a[AW-1:0]);
    a2i = (m == 4) ? int'(a2) : ai;
    chk(acc == (r != 0), tag_of(m), 32'(acc), 32'(r != 0));
    chk(er == (r == 0), "R6", 32'(er), 32'(r == 0));
    if (r == 0 || r == 4) return;
    if (we) begin
      chk(!rv, "R9", 32'(rv), 0);
      if (r == 1) begin rput(0, ai, be[1:0], wd[15:0]); rput(1, a2i, be[3:2], wd[31:16]); end
      else rput(r - 2, ai, be[1:0], wd[15:0]);
    end else begin
      if (r == 1) e = {rget(1, a2i), rget(0, ai)};
      else e = {16'h0, rget(r - 2, ai)};
      chk(rv, "R9", 32'(rv), 1);
      chk(rd == e, tag_of(m), rd, e);
    end
  endtask

  task automatic rnd_ops(input int n, input int m, input bit hon, input bit lon);
    for (int i = 0; i < n; i++) begin
      hv = hon && ($urandom % 2 == 1); hwe = $urandom % 2;
      ha = '0; ha[3:0] = 4'($urandom); ha[AW] = $urandom % 2;
      hbe = 4'($urandom); hwd = $urandom;
      lv = lon && ($urandom % 2 == 1); lwe = $urandom % 2;
      la = '0; la[3:0] = 4'($urandom); la[AW] = (m == 4) ? 1'b0 : 1'($urandom);
      la2 = '0; la2[3:0] = 4'($urandom); lbe = 4'($urandom); lwd = $urandom;
      begin
        bit v1, w1, v2, w2; logic [AW:0] a1, a2x; logic [AW-1:0] a22; logic [3:0] e1, e2;
        logic [31:0] d1, d2;
        v1 = hv; w1 = hwe; a1 = ha; e1 = hbe; d1 = hwd;
        v2 = lv; w2 = lwe; a2x = la; a22 = la2; e2 = lbe; d2 = lwd;
        step();
        judge(1, m, v1, w1, a1, '0, e1, d1, hacc, herr, hrv, hrd);
        judge(0, m, v2, w2, a2x, a22, e2, d2, lacc, lerr, lrv, lrd);
      end
    end
  endtask

  task automatic set_mode(input logic [2:0] c);
    mode_set = 1; mode_code = c;
    @(negedge clk); mode_set = 0;
    for (int i = 0; i < 6 && mode_busy; i++) @(negedge clk);
    chk(mode_cur == c && !mode_busy, "R7", 32'(mode_cur), 32'(c));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mode_cur == 0 && !mode_busy, "R1", 32'(mode_cur), 0);
    chk(!irq && !h_rvalid && !l_rvalid, "R1", {29'h0, irq, h_rvalid, l_rvalid}, 0);

    // R2 pin mapping of a wide host write, top address bit disregarded
    hv = 1; hwe = 1; ha = '0; ha[AW] = 1; ha[4:0] = 5'd21; hbe = 4'hF; hwd = 32'hA1B2_C3D4;
    #1;
    chk(b0_en && b1_en && b0_addr == 21 && b1_addr == 21, "R2", {b1_addr[15:0], b0_addr[15:0]}, 32'h0015_0015);
    chk(b0_wdata == 16'hC3D4 && b1_wdata == 16'hA1B2 && b0_be == 2'b11 && b1_be == 2'b11,
        "R2", {b1_wdata, b0_wdata}, 32'hA1B2_C3D4);
    #0 step(); judge(1, 0, 1, 1, ha, '0, 4'hF, 32'hA1B2_C3D4, hacc, herr, hrv, hrd);
    // R2 partial write: only byte 2 (bank 1 low byte)
    hv = 1; hwe = 1; ha = 21; hbe = 4'b0100; hwd = 32'h0077_0000;
    #1; chk(b1_be == 2'b01 && b0_be == 2'b00, "R2", {28'h0, b1_be, b0_be}, 32'h4);
    step(); judge(1, 0, 1, 1, ha, '0, 4'b0100, 32'h0077_0000, hacc, herr, hrv, hrd);
    hv = 1; hwe = 0; ha = 21; step();
    chk(hrv && hrd == 32'hA177_C3D4, "R2", hrd, 32'hA177_C3D4);

    // R6 logic side rejected in mode 0, nothing forwarded
    lv = 1; lwe = 1; la = 3; lbe = 4'hF; lwd = 32'hDEAD_BEEF;
    step();
    chk(!lacc && lerr && !en0 && !en1, "R6", {28'h0, lacc, lerr, en0, en1}, 32'h4);

    rnd_ops(200, 0, 1, 1);

    // R7 ignored codes
    mode_set = 1; mode_code = 3'd6; @(negedge clk); mode_set = 0; @(negedge clk);
    chk(!mode_busy && mode_cur == 0, "R7", {28'h0, mode_busy, mode_cur}, 0);

    // R7 mode change with a read in flight
    hv = 1; hwe = 0; ha = 21; mode_set = 1; mode_code = 3'd2;
    #1; hacc = h_ready;
    @(negedge clk); mode_set = 0;
    chk(hacc && h_rvalid && h_rdata == 32'hA177_C3D4, "R7", h_rdata, 32'hA177_C3D4);
    chk(mode_busy && mode_cur == 0 && !h_ready, "R7", {27'h0, h_ready, mode_busy, mode_cur}, 32'h8);
    hv = 0;
    @(negedge clk);
    chk(mode_busy && mode_cur == 0, "R7", {28'h0, mode_busy, mode_cur}, 32'h8);
    @(negedge clk);
    chk(!mode_busy && mode_cur == 2, "R7", {28'h0, mode_busy, mode_cur}, 32'h2);

    // R4 split A: host on bank 0 reads low half of the wide word
    hv = 1; hwe = 0; ha = 21; step();
    chk(hrv && hrd == 32'h0000_C3D4, "R4", hrd, 32'h0000_C3D4);
    hv = 1; hwe = 0; ha = '0; ha[AW] = 1; ha[4:0] = 21; step();
    chk(!hacc && herr, "R6", {30'h0, hacc, herr}, 1);
    rnd_ops(300, 2, 1, 1);
    set_mode(3'd3);
    lv = 1; lwe = 0; la = 21; step();
    chk(lrv && lrd == 32'h0000_C3D4, "R4", lrd, 32'h0000_C3D4);
    rnd_ops(300, 3, 1, 1);

    // R3 logic wide
    set_mode(3'd1);
    rnd_ops(200, 1, 1, 1);

    // R5 dual
    set_mode(3'd4);
    lv = 1; lwe = 1; la = 5; la2 = 9; lbe = 4'hF; lwd = 32'h1357_2468;
    #1; chk(b0_addr == 5 && b1_addr == 9 && b1_wdata == 16'h1357, "R5",
            {b1_addr[7:0], b0_addr[7:0], b1_wdata}, 32'h0905_1357);
    step(); judge(0, 4, 1, 1, la, la2, 4'hF, 32'h1357_2468, lacc, lerr, lrv, lrd);
    rnd_ops(300, 4, 1, 1);

    // R8 doorbell
    chk(!irq, "R8", 32'(irq), 0);
    lv = 1; lwe = 1; la = '0; la[AW] = 1; step();
    chk(lacc && irq && !en0 && !en1, "R8", {29'h0, lacc, irq, en0 | en1}, 32'h6);
    repeat (3) @(negedge clk);
    chk(irq, "R8", 32'(irq), 1);
    hv = 1; hwe = 1; ha = '0; ha[AW] = 1; step();
    chk(hacc && !irq, "R8", {30'h0, hacc, irq}, 32'h2);
    hv = 1; hwe = 1; ha = '0; ha[AW] = 1; lv = 1; lwe = 1; la = '0; la[AW] = 1; step();
    chk(irq, "R8", 32'(irq), 1);
    hv = 1; hwe = 0; ha = '0; ha[AW] = 1; step();
    chk(!hacc && herr && irq, "R6", {29'h0, hacc, herr, irq}, 32'h3);
    lv = 1; lwe = 0; la = '0; la[AW] = 1; step();
    chk(!lacc && lerr && !lrv, "R6", {29'h0, lacc, lerr, lrv}, 32'h2);

    // back to host wide: data written in the other modes is visible
    set_mode(3'd0);
    for (int k = 0; k < 16; k++) begin
      hv = 1; hwe = 0; ha = AW'(k); step();
      chk(hrv && hrd == {rget(1, k), rget(0, k)}, "R2", hrd, {rget(1, k), rget(0, k)});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule